// File: doc/BRIEF.md
# Debug Halt Entry Controller

This controller decides when a processor core is parked in a halted debug state and when it is released. A host request, or a qualifying debug event routed as an exception, asks for entry. Entry is taken at once when the core is clocked (running, stopped or waiting). When the core clock is frozen, the request is parked in a pending state until the clock is back. The host leaves the halted state with an exit command. Reset always leaves it.

Three event sources are qualified by per-source enable bits in a small mode register: an event-selector match, a host write to the receive register, and a host read of the transmit register. A routing bit sends every qualifying event either to an in-core debug exception pulse or to an interrupt pulse for an external interrupt controller. No other mask can block the event. A separate halt-enable bit permits all conditions that force the halted state.

States: RUN (normal), PEND (request accepted, core clock frozen), HALT (debug state). Transitions: RUN→HALT on an enabled request with a live clock; RUN→PEND on an enabled request with a frozen clock; PEND→HALT when the clock is live; HALT→RUN on the exit command; any state→RUN on reset.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: With halt-enable (mode bit 4) set and the core live (core_frozen low and one of core_run, core_stop or core_wait high), a host_halt_req sampled at a clock edge drives in_halt high from that edge onward.
- R2: If the core is not live when an enabled request is sampled, in_halt stays low while it is not live. in_halt rises at the first edge that samples the core live.
- R3: exit_cmd sampled while in_halt is high clears in_halt at that edge. exit_cmd has no effect outside the halted state.
- R4: An asynchronous active-low rst_n clears in_halt, dbg_exc, dbg_irq and the whole mode register.
- R5: The routing bit (mode bit 0) sends each qualifying event to a one-cycle pulse one edge later. The pulse goes to dbg_irq when the bit is 1 and to dbg_exc when it is 0. The two outputs are never high together.
- R6: An event qualifies only when its source enable is set: bit 3 for sel_match, bit 1 for rx_wr_stb, bit 2 for tx_rd_stb. A source whose enable is clear produces no pulse and no entry.
- R7: With halt-enable clear, no request causes entry. With halt-enable set, a qualifying event routed to dbg_exc also causes entry, with the same timing as R1. An event routed to dbg_irq never causes entry.
- R8: While in_halt is high, further requests and events leave it high until exit_cmd or reset.
- R9: Qualifying events from several sources in the same cycle are merged into a single one-cycle pulse.
- R10: mode_wr loads mode_wdata into the mode register at the clock edge. The new value governs events and requests from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_halt_req | input | 1 | Host debug request |
| core_run | input | 1 | Core executing |
| core_stop | input | 1 | Core in stop low-power state |
| core_wait | input | 1 | Core in wait low-power state |
| core_frozen | input | 1 | Core clock stopped |
| sel_match | input | 1 | Event-selector match |
| rx_wr_stb | input | 1 | Host wrote receive register (one-cycle pulse) |
| tx_rd_stb | input | 1 | Host read transmit register (one-cycle pulse) |
| exit_cmd | input | 1 | Exit command bit from host |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 5 | Mode write data: bit0 route, bit1 rx, bit2 tx, bit3 selector, bit4 halt-enable |
| in_halt | output | 1 | Debug-state indication (registered) |
| dbg_exc | output | 1 | Debug exception request pulse |
| dbg_irq | output | 1 | Interrupt pulse to external controller |

## Verification
The assertions assume that inputs change only between clock edges and that a source whose enable is clear in the mode register is simply ignored. They do not assume the strobes are single-cycle, so back-to-back events are legal stimulus. The random stimulus holds core_frozen high for runs of cycles and rewrites the mode register now and then with arbitrary values. This reaches the pending path, disabled sources and both routings, and every input stays a clean value sampled away from the edge.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PEND = 2'd1,
        ST_HALT = 2'd2
    } halt_st_e;

    localparam int MODE_W      = 5;
    localparam int ROUTE_BIT   = 0;
    localparam int RX_BIT      = 1;
    localparam int TX_BIT      = 2;
    localparam int SEL_BIT     = 3;
    localparam int HALT_EN_BIT = 4;
    localparam int NSRC        = 3;

endpackage

// File: rtl/dbg_mode_reg.sv
module dbg_mode_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr)
            q <= wdata;
    end
endmodule

// File: rtl/dbg_evt_route.sv
module dbg_evt_route #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_hit,
    input  logic [NSRC-1:0] src_en,
    input  logic            route_irq,
    output logic            evt_exc_now,
    output logic            exc_q,
    output logic            irq_q
);
    logic [NSRC-1:0] qual;
    logic            evt_any;

    for (genvar i = 0; i < NSRC; i++) begin : g_qual
        assign qual[i] = src_hit[i] & src_en[i];
    end

    assign evt_any     = |qual;
    assign evt_exc_now = evt_any & ~route_irq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            exc_q <= evt_any & ~route_irq;
            irq_q <= evt_any & route_irq;
        end
    end
endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm
    import dbg_halt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic halt_en,
    input  logic core_live,
    input  logic exit_cmd,
    output logic in_halt,
    output logic pend
);
    halt_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_RUN;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (req && halt_en)
                    st_d = core_live ? ST_HALT : ST_PEND;
            end
            ST_PEND: begin
                if (core_live)
                    st_d = ST_HALT;
            end
            ST_HALT: begin
                if (exit_cmd)
                    st_d = ST_RUN;
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_comb begin
        in_halt = 1'b0;
        pend    = 1'b0;
        unique case (st_q)
            ST_RUN:  ;
            ST_PEND: pend    = 1'b1;
            ST_HALT: in_halt = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_halt_req,
    input  logic              core_run,
    input  logic              core_stop,
    input  logic              core_wait,
    input  logic              core_frozen,
    input  logic              sel_match,
    input  logic              rx_wr_stb,
    input  logic              tx_rd_stb,
    input  logic              exit_cmd,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic              in_halt,
    output logic              dbg_exc,
    output logic              dbg_irq
);
    logic [MODE_W-1:0] mode_q;
    logic [NSRC-1:0]   src_hit;
    logic [NSRC-1:0]   src_en;
    logic              evt_exc_now;
    logic              core_live;
    logic              fsm_pend;

    assign src_hit   = {sel_match, tx_rd_stb, rx_wr_stb};
    assign src_en    = {mode_q[SEL_BIT], mode_q[TX_BIT], mode_q[RX_BIT]};
    assign core_live = ~core_frozen & (core_run | core_stop | core_wait);

    dbg_mode_reg #(.W(MODE_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mode_wr),
        .wdata (mode_wdata),
        .q     (mode_q)
    );

    dbg_evt_route #(.NSRC(NSRC)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_hit     (src_hit),
        .src_en      (src_en),
        .route_irq   (mode_q[ROUTE_BIT]),
        .evt_exc_now (evt_exc_now),
        .exc_q       (dbg_exc),
        .irq_q       (dbg_irq)
    );

    dbg_halt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (host_halt_req | evt_exc_now),
        .halt_en   (mode_q[HALT_EN_BIT]),
        .core_live (core_live),
        .exit_cmd  (exit_cmd),
        .in_halt   (in_halt),
        .pend      (fsm_pend)
    );
endmodule

// File: rtl/dbg_halt_chk.sv
module dbg_halt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       core_frozen,
    input logic       sel_match,
    input logic       rx_wr_stb,
    input logic       tx_rd_stb,
    input logic       exit_cmd,
    input logic [4:0] mode_q,
    input logic       fsm_pend,
    input logic       in_halt,
    input logic       dbg_exc,
    input logic       dbg_irq
);
    logic qual_any;
    assign qual_any = (sel_match & mode_q[3]) | (rx_wr_stb & mode_q[1]) | (tx_rd_stb & mode_q[2]);

    AST_EXC_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_exc && dbg_irq)); // R5
    AST_EXC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_any || mode_q[0] |=> dbg_exc == 1'b0); // R6
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_any || !mode_q[0] |=> dbg_irq == 1'b0); // R5
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_halt && core_frozen) |=> !in_halt); // R2
    AST_EXIT_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_halt && exit_cmd) |=> !in_halt); // R3
    AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_halt && !exit_cmd) |=> in_halt); // R8
    AST_NO_ENTRY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_halt && !fsm_pend && !mode_q[4]) |=> !in_halt); // R7
endmodule

bind dbg_halt_ctrl dbg_halt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_frozen (core_frozen),
    .sel_match   (sel_match),
    .rx_wr_stb   (rx_wr_stb),
    .tx_rd_stb   (tx_rd_stb),
    .exit_cmd    (exit_cmd),
    .mode_q      (mode_q),
    .fsm_pend    (fsm_pend),
    .in_halt     (in_halt),
    .dbg_exc     (dbg_exc),
    .dbg_irq     (dbg_irq)
);

// File: tb/dbg_halt_ctrl_test.sv
module dbg_halt_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_halt_req = 0, core_run = 0, core_stop = 0, core_wait = 0, core_frozen = 0;
    logic sel_match = 0, rx_wr_stb = 0, tx_rd_stb = 0, exit_cmd = 0, mode_wr = 0;
    logic [4:0] mode_wdata = '0;
    logic in_halt, dbg_exc, dbg_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model: 0 run, 1 pending, 2 halted
    logic [1:0] m_st = 2'd0;
    logic [4:0] m_mode = '0;
    logic       m_exc = 0, m_irq = 0;

    always #4 clk = ~clk;

    dbg_halt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .host_halt_req(host_halt_req),
        .core_run(core_run), .core_stop(core_stop), .core_wait(core_wait),
        .core_frozen(core_frozen), .sel_match(sel_match), .rx_wr_stb(rx_wr_stb),
        .tx_rd_stb(tx_rd_stb), .exit_cmd(exit_cmd), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .in_halt(in_halt), .dbg_exc(dbg_exc), .dbg_irq(dbg_irq)
    );

    function automatic logic qual_evt(logic [4:0] md, logic s, logic r, logic t);
        return (s & md[3]) | (r & md[1]) | (t & md[2]);
    endfunction

    function automatic logic [1:0] next_st(logic [1:0] s, logic req, logic en,
                                            logic live, logic ex);
        case (s)
            2'd0:    return (req && en) ? (live ? 2'd2 : 2'd1) : 2'd0;
            2'd1:    return live ? 2'd2 : 2'd1;
            2'd2:    return ex ? 2'd0 : 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0b exp=%0b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "in_halt", in_halt, m_st == 2'd2);
        check(tag, "dbg_exc", dbg_exc, m_exc);
        check(tag, "dbg_irq", dbg_irq, m_irq);
    endtask

    task automatic tick(string tag);
        logic ev, live;
        ev   = qual_evt(m_mode, sel_match, rx_wr_stb, tx_rd_stb);
        live = !core_frozen && (core_run || core_stop || core_wait);
        @(posedge clk);
        m_st  = next_st(m_st, host_halt_req | (ev & ~m_mode[0]), m_mode[4], live, exit_cmd);
        m_exc = ev & ~m_mode[0];
        m_irq = ev & m_mode[0];
        if (mode_wr) m_mode = mode_wdata;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic clear_pulses();
        host_halt_req = 0; sel_match = 0; rx_wr_stb = 0; tx_rd_stb = 0;
        exit_cmd = 0; mode_wr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        m_st = 2'd0; m_mode = '0; m_exc = 0; m_irq = 0;
        @(negedge clk);
        check_all("R4");
        rst_n = 1;
    endtask

    task automatic set_mode(logic [4:0] v);
        mode_wr = 1; mode_wdata = v;
        tick("R10");
        mode_wr = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        do_reset();
        core_run = 1;

        // R7: halt-enable clear blocks entry
        host_halt_req = 1; tick("R7"); clear_pulses(); tick("R7");
        // R1: host request with halt-enable
        set_mode(5'b10000);
        host_halt_req = 1; tick("R1"); clear_pulses(); tick("R1");
        // R8: more requests ignored while halted
        host_halt_req = 1; rx_wr_stb = 1; tick("R8"); clear_pulses(); tick("R8");
        // R3: exit
        exit_cmd = 1; tick("R3"); clear_pulses(); tick("R3");
        exit_cmd = 1; tick("R3"); clear_pulses();
        // R6/R7: rx event routed to exception enters debug state
        set_mode(5'b10010);
        rx_wr_stb = 1; tick("R6"); clear_pulses(); tick("R7");
        exit_cmd = 1; tick("R3"); clear_pulses();
        // R6: disabled sources do nothing
        set_mode(5'b10000);
        sel_match = 1; rx_wr_stb = 1; tx_rd_stb = 1; tick("R6"); clear_pulses(); tick("R6");
        // R9/R5: all sources at once, routed to irq, no entry
        set_mode(5'b11111);
        sel_match = 1; rx_wr_stb = 1; tx_rd_stb = 1; tick("R9"); clear_pulses(); tick("R9");
        tx_rd_stb = 1; tick("R5"); clear_pulses(); tick("R5");
        // R2: frozen core delays entry
        set_mode(5'b10000);
        core_frozen = 1; host_halt_req = 1; tick("R2"); clear_pulses();
        tick("R2"); tick("R2"); tick("R2");
        core_frozen = 0; tick("R2"); tick("R2");
        // R4: reset while halted
        do_reset();
        tick("R4");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            host_halt_req = ($urandom_range(0, 9) == 0);
            sel_match     = ($urandom_range(0, 5) == 0);
            rx_wr_stb     = ($urandom_range(0, 5) == 0);
            tx_rd_stb     = ($urandom_range(0, 5) == 0);
            exit_cmd      = ($urandom_range(0, 7) == 0);
            mode_wr       = ($urandom_range(0, 15) == 0);
            mode_wdata    = 5'($urandom);
            if ($urandom_range(0, 19) == 0) core_frozen = ~core_frozen;
            core_run  = $urandom_range(0, 1);
            core_stop = ($urandom_range(0, 3) == 0);
            core_wait = ($urandom_range(0, 3) == 0);
            tick("R5");
        end
        clear_pulses();
        tick("R5");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule